// File: doc/BRIEF.md
# Nametable Mirroring Controller

This block sits on a game-cartridge edge connector and turns CPU writes in the upper half of the address space into a small mirroring control register. From that register and the video address bus it drives the bank-select line and the active-low chip enable of the console's internal 2 KB video RAM. Software can choose vertical or horizontal nametable mirroring, or pin the video RAM to either of its two 1 KB halves.

A fast reference clock samples the CPU bus. The CPU clock phase, read/write, the active-low upper-half select, the address and the data pass together through one synchronizer chain, so they stay aligned. While the delayed phase is high, the block keeps capturing the bus. When it sees the phase fall, it commits the last captured value, but only if that cycle was a write to the upper half. The video-side outputs are a pure function of the register and the video address. They follow the video bus with no clock delay.

Top module: `mirr_ctrl_top`

## Requirements
- R1: While reset is asserted, and after it is released, the register is in mode 00 (single screen, lower bank), so `vram_bank` is 0 for every video address.
- R2: A CPU cycle commits data bits [1:0] to the mode register when three conditions hold while `cpu_m2` is high: `cpu_rw` is 0, `cpu_hi_sel_n` is 0 and the address matches the decode. The new mode drives the outputs from the third rising clock edge after `cpu_m2` is driven low. With the default decode, any address from $8000 to $FFFF matches.
- R3: In mode 00, `vram_bank` is 0.
- R4: In mode 01 (single screen, upper bank), `vram_bank` is 1.
- R5: In mode 10 (vertical), `vram_bank` equals `vid_addr[10]`.
- R6: In mode 11 (horizontal), `vram_bank` equals `vid_addr[11]`.
- R7: In every mode, `vram_ce_n` equals the inverse of `vid_addr[13]`, so the video RAM is enabled only at $2000 and above.
- R8: A read cycle (`cpu_rw` = 1) in the upper half leaves the mode unchanged.
- R9: A write cycle during which `cpu_hi_sel_n` stays high (an address below $8000) leaves the mode unchanged.
- R10: Data bits [7:2] of a register write have no effect on the mode.
- R11: The value committed is the one on the data bus while `cpu_m2` was high. Data that changes together with, or after, the fall of `cpu_m2` is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_m2 | input | 1 | CPU clock phase; the bus is valid while it is high |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_hi_sel_n | input | 1 | Active low: the CPU phase is high and address bit 15 is set |
| cpu_addr | input | 15 | CPU address bits 14..0 |
| cpu_data | input | 8 | CPU data bus |
| vid_addr | input | 14 | Video address bits 13..0 |
| vram_bank | output | 1 | Bank select (address bit 10) of the internal video RAM |
| vram_ce_n | output | 1 | Active-low chip enable of the internal video RAM |

## Verification
There are two timings to check. A register write reaches `vram_bank` on the third rising edge after `cpu_m2` is driven low: two synchronizer stages, then the register itself. `vram_bank` and `vram_ce_n` follow `vid_addr` in the same cycle. The bench drives and samples only at falling clock edges. After each bus cycle it waits four falling edges, one more than the write needs, before it sweeps the video address. For each address it checks one nanosecond after the change, so the combinational path is observed with no clock edge in between. The late-data case flips the data bus in the same instant that `cpu_m2` falls, which tests that the value committed is the one aligned with the delayed phase.

// File: rtl/mirr_pkg.sv
package mirr_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MIR_ONE_LO = 2'b00,
    MIR_ONE_HI = 2'b01,
    MIR_VERT   = 2'b10,
    MIR_HORZ   = 2'b11
  } mir_mode_e;
endpackage

// File: rtl/mirr_rst_sync.sv
module mirr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/mirr_bus_sampler.sv
module mirr_bus_sampler #(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 15,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] REG_MASK    = '0,
  parameter logic [ADDR_W-1:0] REG_MATCH   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_m2,
  input  logic              cpu_rw,
  input  logic              cpu_hi_sel_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BUS_W  = 3 + ADDR_W + DATA_W;
  localparam int PHI_B  = BUS_W - 1;
  localparam int RW_B   = BUS_W - 2;
  localparam int SEL_B  = BUS_W - 3;
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b0, 1'b1, 1'b1, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

  logic [BUS_W-1:0] bus_in;
  logic [BUS_W-1:0] chain_q [SYNC_STAGES];
  logic [BUS_W-1:0] chain_d [SYNC_STAGES];

  assign bus_in = {cpu_m2, cpu_rw, cpu_hi_sel_n, cpu_addr, cpu_data};

  // Whole bus travels through the same stages so phase, strobes and data stay aligned.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign chain_d[g] = bus_in;
    end else begin : g_tail
      assign chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= BUS_IDLE;
      else        chain_q[g] <= chain_d[g];
    end
  end

  logic [BUS_W-1:0]  dly;
  logic              d_phi;
  logic              d_rw;
  logic              d_sel_n;
  logic [ADDR_W-1:0] d_addr;
  logic [DATA_W-1:0] d_data;
  logic              addr_hit;

  assign dly     = chain_q[SYNC_STAGES-1];
  assign d_phi   = dly[PHI_B];
  assign d_rw    = dly[RW_B];
  assign d_sel_n = dly[SEL_B];
  assign d_addr  = dly[DATA_W +: ADDR_W];
  assign d_data  = dly[DATA_W-1:0];
  assign addr_hit = ((d_addr & REG_MASK) == REG_MATCH);

  logic              phi_prev_q, phi_prev_d;
  logic              hit_q, hit_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cap_en;

  assign cap_en = d_phi;

  always_comb begin
    phi_prev_d = d_phi;
    hit_d      = hit_q;
    data_d     = data_q;
    if (cap_en) begin
      hit_d  = !d_rw && !d_sel_n && addr_hit;
      data_d = d_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_prev_q <= 1'b0;
      hit_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      phi_prev_q <= phi_prev_d;
      hit_q      <= hit_d;
      data_q     <= data_d;
    end
  end

  assign wr_stb  = phi_prev_q && !d_phi && hit_q;
  assign wr_data = data_q;
endmodule

// File: rtl/mirr_mode_reg.sv
module mirr_mode_reg
  import mirr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output mir_mode_e         mode
);
  localparam int MODE_LSB = 0;

  mir_mode_e mode_q, mode_d;
  logic      unused_hi_bits;

  assign unused_hi_bits = ^wr_data[DATA_W-1:MODE_LSB+MODE_W];

  always_comb begin
    mode_d = mode_q;
    if (wr_stb) mode_d = mir_mode_e'(wr_data[MODE_LSB +: MODE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MIR_ONE_LO;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/mirr_nt_map.sv
module mirr_nt_map
  import mirr_pkg::*;
#(
  parameter int VID_AW      = 14,
  parameter int NT_BANK_BIT = 10
) (
  input  mir_mode_e         mode,
  input  logic [VID_AW-1:0] vid_addr,
  output logic              vram_bank,
  output logic              vram_ce_n
);
  localparam int VERT_BIT = NT_BANK_BIT;
  localparam int HORZ_BIT = NT_BANK_BIT + 1;
  localparam int CE_BIT   = VID_AW - 1;

  always_comb begin
    unique case (mode)
      MIR_ONE_LO: vram_bank = 1'b0;
      MIR_ONE_HI: vram_bank = 1'b1;
      MIR_VERT:   vram_bank = vid_addr[VERT_BIT];
      MIR_HORZ:   vram_bank = vid_addr[HORZ_BIT];
      default:    vram_bank = 1'b0;
    endcase
  end

  assign vram_ce_n = ~vid_addr[CE_BIT];
endmodule

// File: rtl/mirr_ctrl_top.sv
module mirr_ctrl_top
  import mirr_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2,
  parameter int                ADDR_W      = 15,
  parameter int                DATA_W      = 8,
  parameter int                VID_AW      = 14,
  parameter logic [ADDR_W-1:0] REG_MASK    = '0,
  parameter logic [ADDR_W-1:0] REG_MATCH   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_m2,
  input  logic              cpu_rw,
  input  logic              cpu_hi_sel_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic [VID_AW-1:0] vid_addr,
  output logic              vram_bank,
  output logic              vram_ce_n
);
  logic              rst_sync_n;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data;
  mir_mode_e         mode_q;

  mirr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mirr_bus_sampler #(
    .SYNC_STAGES (SYNC_STAGES),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REG_MASK    (REG_MASK),
    .REG_MATCH   (REG_MATCH)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cpu_m2       (cpu_m2),
    .cpu_rw       (cpu_rw),
    .cpu_hi_sel_n (cpu_hi_sel_n),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .wr_stb       (wr_stb),
    .wr_data      (wr_data)
  );

  mirr_mode_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .mode    (mode_q)
  );

  mirr_nt_map #(.VID_AW(VID_AW)) u_map (
    .mode      (mode_q),
    .vid_addr  (vid_addr),
    .vram_bank (vram_bank),
    .vram_ce_n (vram_ce_n)
  );
endmodule

// File: rtl/mirr_ctrl_chk.sv
module mirr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_stb,
  input logic [1:0]  wr_bits,
  input logic [1:0]  mode,
  input logic [13:0] vid_addr,
  input logic        vram_bank,
  input logic        vram_ce_n
);
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (mode == $past(wr_bits)));                       // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mode));                                 // R8
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);                                        // R2
  AST_ONE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !vram_bank);                            // R3
  AST_ONE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> vram_bank);                             // R4
  AST_VERT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (vram_bank == vid_addr[10]));           // R5
  AST_HORZ_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (vram_bank == vid_addr[11]));           // R6
  AST_CE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    vram_ce_n != vid_addr[13]);                                 // R7
endmodule

bind mirr_ctrl_top mirr_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .wr_bits   (wr_data[1:0]),
  .mode      (mode_q),
  .vid_addr  (vid_addr),
  .vram_bank (vram_bank),
  .vram_ce_n (vram_ce_n)
);

// File: tb/mirr_ctrl_top_test.sv
`timescale 1ns/1ps
module mirr_ctrl_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_m2;
  logic        cpu_rw;
  logic        cpu_hi_sel_n;
  logic [14:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic [13:0] vid_addr;
  logic        vram_bank;
  logic        vram_ce_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mirr_ctrl_top uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_m2       (cpu_m2),
    .cpu_rw       (cpu_rw),
    .cpu_hi_sel_n (cpu_hi_sel_n),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .vid_addr     (vid_addr),
    .vram_bank    (vram_bank),
    .vram_ce_n    (vram_ce_n)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Sweep video addresses across bits 9..13; expected bank from the mode table of R3..R6.
  task automatic sweep(input logic [1:0] m, input string req);
    for (int i = 0; i < 32; i++) begin
      logic [13:0] a;
      logic        exp_bank;
      a = 14'(i * 14'h200 + 14'h2B);
      vid_addr = a;
      #1;
      case (m)
        2'b00:   exp_bank = 1'b0;
        2'b01:   exp_bank = 1'b1;
        2'b10:   exp_bank = a[10];
        default: exp_bank = a[11];
      endcase
      check(req, $sformatf("bank @%04h", a), vram_bank, exp_bank);
      check("R7", $sformatf("ce_n @%04h", a), vram_ce_n, ~a[13]);
    end
  endtask

  // One CPU bus cycle; data flips as the phase falls (R11).
  task automatic cpu_cycle(input logic [15:0] a, input logic [7:0] d, input logic wr);
    @(negedge clk);
    cpu_m2 = 1'b0; cpu_hi_sel_n = 1'b1; cpu_rw = ~wr;
    cpu_addr = a[14:0]; cpu_data = d;
    repeat (2) @(negedge clk);
    cpu_m2 = 1'b1; cpu_hi_sel_n = ~a[15];
    repeat (4) @(negedge clk);
    cpu_m2 = 1'b0; cpu_hi_sel_n = 1'b1; cpu_data = ~d;
    repeat (4) @(negedge clk);
    cpu_rw = 1'b1;
  endtask

  task automatic t_reset;
    sweep(2'b00, "R1");
  endtask

  task automatic t_modes;
    cpu_cycle(16'h8000, 8'h01, 1'b1); sweep(2'b01, "R4");
    cpu_cycle(16'hC123, 8'h02, 1'b1); sweep(2'b10, "R5");
    cpu_cycle(16'hFFFF, 8'h03, 1'b1); sweep(2'b11, "R6");
    cpu_cycle(16'hA000, 8'h00, 1'b1); sweep(2'b00, "R3");
    cpu_cycle(16'h9000, 8'h02, 1'b1); sweep(2'b10, "R2");
  endtask

  task automatic t_read_ignored;
    cpu_cycle(16'h8000, 8'h01, 1'b0); sweep(2'b10, "R8");
    cpu_cycle(16'hE000, 8'h03, 1'b0); sweep(2'b10, "R8");
  endtask

  task automatic t_low_write;
    cpu_cycle(16'h6000, 8'h01, 1'b1); sweep(2'b10, "R9");
    cpu_cycle(16'h0000, 8'h03, 1'b1); sweep(2'b10, "R9");
    cpu_cycle(16'h7FFF, 8'h00, 1'b1); sweep(2'b10, "R9");
  endtask

  task automatic t_high_bits;
    cpu_cycle(16'h8000, 8'hFD, 1'b1); sweep(2'b01, "R10");
    cpu_cycle(16'h8000, 8'h83, 1'b1); sweep(2'b11, "R10");
  endtask

  task automatic t_late_data;
    // Bus shows ~0x02 = 0xFD (mode 01) after the fall; 0x02 must be kept.
    cpu_cycle(16'hB000, 8'h02, 1'b1); sweep(2'b10, "R11");
  endtask

  task automatic t_reset_midrun;
    cpu_cycle(16'h8000, 8'h03, 1'b1); sweep(2'b11, "R6");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sweep(2'b00, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep(2'b00, "R1");
  endtask

  initial begin
    rst_n = 1'b0; cpu_m2 = 1'b0; cpu_rw = 1'b1; cpu_hi_sel_n = 1'b1;
    cpu_addr = '0; cpu_data = '0; vid_addr = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_modes;
    t_read_ignored;
    t_low_write;
    t_high_bits;
    t_late_data;
    t_reset_midrun;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule